// File: doc/BRIEF.md
# Multifunction Control Pin Decoder

This block gives two external control pins a meaning chosen by four configuration bits. The reference-side pin can act as a device power-down, as an output enable for the reference output, as the select of the reference-output mux (master clock or prescaled clock), or as a shutdown for the whole reference circuitry. Three configuration bits pick among these roles by priority. The main-side pin is either a device power-down or an output enable for the main output, chosen by one bit.

Both pins pass through a two-flop synchronizer on the master clock before they are decoded. The configuration bits are captured into a register that resets to the default role set. The outputs are decoded levels for the downstream gating and power logic: a reference enable, a main enable, one combined power-down request, a reference shutdown flag and the reference mux select. Clock division and the timing of output gating belong to other blocks.

Top module: `ctrl_pin_decoder`

## Requirements
- R1: A change on either pin reaches the outputs after exactly two rising clock edges (`SYNC_STAGES` = 2). A change on a configuration input reaches the outputs after exactly one rising edge.
- R2: When `cfg_ref_pdn_i` is 1, the reference pin is a device power-down (pin 1 requests power-down). `ref_en_o` is 1 and `ref_sel_o` equals `cfg_ref_pick_i`, whatever `cfg_ref_gate_i` is.
- R3: When `cfg_ref_pdn_i` is 0 and `cfg_ref_gate_i` is 1, `ref_en_o` follows the reference pin (1 enables, 0 disables) and `ref_sel_o` equals `cfg_ref_pick_i`.
- R4: When `cfg_ref_pdn_i` and `cfg_ref_gate_i` are 0 and `cfg_ref_pick_i` is 1, `ref_sel_o` follows the reference pin (0 = master clock, 1 = prescaled clock) and `ref_en_o` is 1.
- R5: When `cfg_ref_pdn_i`, `cfg_ref_gate_i` and `cfg_ref_pick_i` are all 0, a 1 on the reference pin sets `ref_off_o` and clears `ref_en_o`; a 0 sets `ref_en_o`. `ref_sel_o` is 0, and the reference pin never requests device power-down.
- R6: `ref_off_o` is 0 in every role except the all-zero role of R5.
- R7: When `cfg_main_pdn_i` is 1, the main pin is a device power-down (1 requests) and `main_en_o` is 1.
- R8: When `cfg_main_pdn_i` is 0, `main_en_o` follows the main pin (1 enables) and the main pin requests no power-down.
- R9: `pdn_req_o` is 1 exactly when at least one pin in a power-down role is at 1.
- R10: During reset the configuration register holds gate = 1, pick = 1 and both power-down bits = 0, and the synchronized pins are 0. So `ref_en_o` = 0, `main_en_o` = 0, `pdn_req_o` = 0, `ref_off_o` = 0 and `ref_sel_o` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_ref_i | input | 1 | Asynchronous reference-side control pin |
| pin_main_i | input | 1 | Asynchronous main-side control pin |
| cfg_ref_gate_i | input | 1 | Reference pin acts as output enable |
| cfg_ref_pick_i | input | 1 | Reference frequency pick / pin-driven mux |
| cfg_ref_pdn_i | input | 1 | Reference pin acts as device power-down |
| cfg_main_pdn_i | input | 1 | Main pin acts as device power-down |
| ref_en_o | output | 1 | Reference output enable |
| main_en_o | output | 1 | Main output enable |
| pdn_req_o | output | 1 | Combined device power-down request |
| ref_off_o | output | 1 | Shut down all reference circuitry |
| ref_sel_o | output | 1 | Reference mux select, 1 = prescaled clock |

## Verification
The bench builds the block with `SYNC_STAGES` = 2. Its reference model uses a history queue of that same length, so the pin latency it predicts comes from the requirement and not from the flop chain. It sweeps all sixteen configuration codes under random pin traffic. This covers every priority branch, including the overriding power-down bit and the all-zero shutdown case, and both power-down sources at once. A reset in the middle of the run shows that the defaults come back.

// File: rtl/ctrl_pin_pkg.sv
package ctrl_pin_pkg;

  typedef enum logic [1:0] {
    ROLE_PWRDN  = 2'd0,
    ROLE_OUTEN  = 2'd1,
    ROLE_MUXSEL = 2'd2,
    ROLE_REFOFF = 2'd3
  } ref_role_e;

  typedef struct packed {
    logic gate;
    logic pick;
    logic ref_pdn;
    logic main_pdn;
  } pin_cfg_t;

  localparam pin_cfg_t CFG_RESET = '{gate: 1'b1, pick: 1'b1, ref_pdn: 1'b0, main_pdn: 1'b0};

  // Priority: power-down bit first, then gate, then pick, else shutdown role.
  function automatic ref_role_e ref_role(input logic gate, input logic pick, input logic pdn);
    ref_role_e r;
    if (pdn)       r = ROLE_PWRDN;
    else if (gate) r = ROLE_OUTEN;
    else if (pick) r = ROLE_MUXSEL;
    else           r = ROLE_REFOFF;
    return r;
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int PREV = (STAGES > 1) ? STAGES - 2 : 0;

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

  if (STAGES > 1) begin : g_chk
    AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      q == $past(stg[PREV])); // R1
  end
endmodule

// File: rtl/cfg_hold.sv
module cfg_hold
  import ctrl_pin_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pin_cfg_t cfg_i,
  output pin_cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_i;
  end
endmodule

// File: rtl/ref_role_decode.sv
module ref_role_decode
  import ctrl_pin_pkg::*;
(
  input  logic      pin,
  input  logic      gate,
  input  logic      pick,
  input  logic      pdn,
  output ref_role_e role_o,
  output logic      en_o,
  output logic      sel_o,
  output logic      off_o,
  output logic      pdn_o
);
  assign role_o = ref_role(gate, pick, pdn);

  always_comb begin
    en_o  = 1'b1;
    sel_o = pick;
    off_o = 1'b0;
    pdn_o = 1'b0;
    unique case (role_o)
      ROLE_PWRDN:  pdn_o = pin;
      ROLE_OUTEN:  en_o  = pin;
      ROLE_MUXSEL: sel_o = pin;
      ROLE_REFOFF: begin
        off_o = pin;
        en_o  = ~pin;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/main_role_decode.sv
module main_role_decode (
  input  logic pin,
  input  logic pdn_mode,
  output logic en_o,
  output logic pdn_o
);
  always_comb begin
    if (pdn_mode) begin
      en_o  = 1'b1;
      pdn_o = pin;
    end else begin
      en_o  = pin;
      pdn_o = 1'b0;
    end
  end
endmodule

// File: rtl/ctrl_pin_decoder.sv
module ctrl_pin_decoder
  import ctrl_pin_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_ref_i,
  input  logic pin_main_i,
  input  logic cfg_ref_gate_i,
  input  logic cfg_ref_pick_i,
  input  logic cfg_ref_pdn_i,
  input  logic cfg_main_pdn_i,
  output logic ref_en_o,
  output logic main_en_o,
  output logic pdn_req_o,
  output logic ref_off_o,
  output logic ref_sel_o
);
  localparam int NPINS = 2;
  localparam int IDX_REF = 0;
  localparam int IDX_MAIN = 1;

  logic [NPINS-1:0] pin_raw, pin_s;
  pin_cfg_t         cfg_in, cfg_q;
  ref_role_e        ref_role_w;
  logic             ref_pdn_w, main_pdn_w;

  assign pin_raw = {pin_main_i, pin_ref_i};
  assign cfg_in  = '{gate: cfg_ref_gate_i, pick: cfg_ref_pick_i,
                     ref_pdn: cfg_ref_pdn_i, main_pdn: cfg_main_pdn_i};

  pin_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_s)
  );

  cfg_hold u_cfg (.clk(clk), .rst_n(rst_n), .cfg_i(cfg_in), .cfg_q(cfg_q));

  ref_role_decode u_ref (
    .pin(pin_s[IDX_REF]), .gate(cfg_q.gate), .pick(cfg_q.pick), .pdn(cfg_q.ref_pdn),
    .role_o(ref_role_w), .en_o(ref_en_o), .sel_o(ref_sel_o), .off_o(ref_off_o),
    .pdn_o(ref_pdn_w)
  );

  main_role_decode u_main (
    .pin(pin_s[IDX_MAIN]), .pdn_mode(cfg_q.main_pdn), .en_o(main_en_o), .pdn_o(main_pdn_w)
  );

  assign pdn_req_o = ref_pdn_w | main_pdn_w;

  AST_OFF_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    ref_off_o |-> !ref_en_o); // R5
  AST_OFF_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_off_o |-> (!cfg_q.gate && !cfg_q.pick && !cfg_q.ref_pdn)); // R6
  AST_PDN_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    pdn_req_o |-> ((pin_s[IDX_REF] && cfg_q.ref_pdn) || (pin_s[IDX_MAIN] && cfg_q.main_pdn))); // R9
  AST_MAIN_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.main_pdn |-> main_en_o); // R7
  AST_SEL_FROM_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.gate || cfg_q.ref_pdn) |-> (ref_sel_o == cfg_q.pick)); // R2
  AST_MUX_FROM_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_role_w == ROLE_MUXSEL) |-> (ref_en_o && ref_sel_o == pin_s[IDX_REF])); // R4
endmodule

// File: tb/tb_ctrl_pin_decoder.sv
module tb_ctrl_pin_decoder;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_ref = 1'b0, pin_main = 1'b0;
  logic c_gate = 1'b0, c_pick = 1'b0, c_rpdn = 1'b0, c_mpdn = 1'b0;
  logic ref_en, main_en, pdn_req, ref_off, ref_sel;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ctrl_pin_decoder #(.SYNC_STAGES(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .pin_ref_i(pin_ref), .pin_main_i(pin_main),
    .cfg_ref_gate_i(c_gate), .cfg_ref_pick_i(c_pick), .cfg_ref_pdn_i(c_rpdn),
    .cfg_main_pdn_i(c_mpdn), .ref_en_o(ref_en), .main_en_o(main_en),
    .pdn_req_o(pdn_req), .ref_off_o(ref_off), .ref_sel_o(ref_sel)
  );

  // Reference model: pin history queue and one-cycle config copy.
  logic [1:0] hist [$];
  logic [3:0] cfg_m;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {};
      for (int i = 0; i < LAT; i++) hist.push_back(2'b00);
      cfg_m = 4'b1100; // gate, pick, rpdn, mpdn
    end else begin
      hist.push_back({pin_main, pin_ref});
      void'(hist.pop_front());
      cfg_m = {c_gate, c_pick, c_rpdn, c_mpdn};
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_cmp();
    logic pr, pm, g, p, rp, mp;
    logic e_en, e_sel, e_off, e_pdn, e_men;
    string t;
    if (hist.size() == 0) return;
    pr = hist[0][0]; pm = hist[0][1];
    {g, p, rp, mp} = cfg_m;
    e_off = 1'b0; e_pdn = 1'b0;
    if (rp)      begin t = "R2"; e_en = 1'b1; e_sel = p; e_pdn = pr; end
    else if (g)  begin t = "R3"; e_en = pr;   e_sel = p; end
    else if (p)  begin t = "R4"; e_en = 1'b1; e_sel = pr; end
    else         begin t = "R5"; e_en = !pr;  e_sel = 1'b0; e_off = pr; end
    if (mp) begin e_men = 1'b1; e_pdn = e_pdn | pm; end
    else    e_men = pm;
    chk(ref_en, e_en, t, "ref_en");
    chk(ref_sel, e_sel, t, "ref_sel");
    chk(ref_off, e_off, "R6", "ref_off");
    chk(main_en, e_men, mp ? "R7" : "R8", "main_en");
    chk(pdn_req, e_pdn, "R9", "pdn_req");
  endtask

  task automatic set_cfg(input logic [3:0] c);
    {c_gate, c_pick, c_rpdn, c_mpdn} = c;
  endtask

  initial begin
    // R10: reset state
    set_cfg(4'b0000);
    repeat (4) @(negedge clk);
    chk(ref_en, 1'b0, "R10", "ref_en in reset");
    chk(main_en, 1'b0, "R10", "main_en in reset");
    chk(pdn_req, 1'b0, "R10", "pdn_req in reset");
    chk(ref_off, 1'b0, "R10", "ref_off in reset");
    chk(ref_sel, 1'b1, "R10", "ref_sel in reset");
    rst_n = 1'b1;

    // R1: config latency one edge, pin latency two edges (gate role)
    set_cfg(4'b1000);
    @(negedge clk);
    chk(ref_sel, 1'b0, "R1", "cfg after 1 edge");
    pin_ref = 1'b1;
    @(negedge clk);
    chk(ref_en, 1'b0, "R1", "pin after 1 edge");
    @(negedge clk);
    chk(ref_en, 1'b1, "R1", "pin after 2 edges");

    // R5 directed: all-zero role, pin high shuts reference
    set_cfg(4'b0000);
    repeat (3) @(negedge clk);
    chk(ref_off, 1'b1, "R5", "ref_off shutdown");
    chk(ref_en, 1'b0, "R5", "ref_en shutdown");
    chk(pdn_req, 1'b0, "R5", "no pdn from ref pin");

    // R9 directed: both power-down sources
    set_cfg(4'b0011);
    pin_ref = 1'b0; pin_main = 1'b1;
    repeat (3) @(negedge clk);
    chk(pdn_req, 1'b1, "R9", "pdn from main pin");
    pin_main = 1'b0;
    repeat (2) @(negedge clk);
    chk(pdn_req, 1'b0, "R9", "pdn released");

    // Sweep all configuration codes with random pin traffic
    for (int c = 0; c < 16; c++) begin
      set_cfg(c[3:0]);
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        model_cmp();
        {pin_main, pin_ref} = 2'($urandom_range(0, 3));
        if (c == 9 && k == 20) rst_n = 1'b0;
        if (c == 9 && k == 23) rst_n = 1'b1;
      end
    end
    @(negedge clk);
    model_cmp();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      mismatched++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule